// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block decides which single interrupt a 16550-style UART reports to software and drives the interrupt line from that decision. It takes level status from the receiver, the receive FIFO and the modem-status unit. It holds the state that register accesses change: the 4-bit interrupt-enable register, the sticky overrun and break flags, and the transmit-holding empty/pending tracker. Every clock it recomputes the highest-priority enabled source and registers both the identification byte and the interrupt line.

The transmit-holding tracker is a three-state machine. HOLD_FULL means the holding register holds a byte, so it is not empty and nothing is pending. EMPTY_ARMED means it is empty and the empty interrupt is pending. EMPTY_QUIET means it is empty and the pending flag has been cleared. The transitions are as follows. A holding write moves any state to HOLD_FULL. A drain pulse moves HOLD_FULL to EMPTY_ARMED. A change of enable bit 1 moves an empty state to EMPTY_ARMED if the bit is now 1, or to EMPTY_QUIET if it is now 0. Reading the identification byte while it shows code 0x2 moves EMPTY_ARMED to EMPTY_QUIET. Reset enters EMPTY_QUIET. When more than one event occurs in a cycle, the holding write is handled first, then the drain pulse, then the enable change, then the acknowledging read.

Top module: `uart_irq_ident`

## Requirements
- R1: Reset state. The identification byte reads 0x01 and irq is 0. The enable register reads 0x00. The line-status byte reads 0x60 when tx_shift_idle is 1.
- R2: The identification byte bits 3:0 carry the source code. Sources are listed here from highest priority to lowest: line status 0x6, character timeout 0xC, received data 0x4, holding empty 0x2, modem status 0x0. If nothing is pending, the code is 0x1. Only the highest-priority enabled pending source is shown.
- R3: Identification bits 7:6 read 11 when fifo_en was 1 at the previous clock and 00 otherwise. Bits 5:4 always read 0.
- R4: The line-status source (0x6) requires enable bit 2 and at least one of these line-status bits: overrun (bit 1), parity (bit 2), framing (bit 3) or break (bit 4).
- R5: The received-data source (0x4) requires enable bit 0 and rx_ready. When fifo_en is 1, it also requires rx_count >= rx_trigger.
- R6: The character-timeout source (0xC) requires char_timeout and enable bit 0.
- R7: The line-status byte is {0, TEMT, THRE, break, framing, parity, overrun, data-ready}. Overrun and break are sticky. A rx_overrun or rx_break pulse sets them. An lsr_rd strobe clears them, but a set pulse in the same cycle wins. Parity and framing follow their inputs and are not cleared by the read.
- R8: An iir_rd strobe while the identification byte shows 0x2 clears the holding-empty pending flag. A read that shows any other code leaves the flag unchanged.
- R9: An enable write that changes bit 1 sets the pending flag if the new bit 1 is 1 and the holding register is empty, and clears it otherwise. An enable write that leaves bit 1 unchanged does not change the pending flag.
- R10: A thr_wr strobe clears THRE (bit 5), TEMT (bit 6) and the pending flag. A later thr_drained pulse sets THRE and the pending flag. TEMT equals THRE AND tx_shift_idle.
- R11: The identification byte and irq are registered from the state and inputs present at the previous clock edge. irq is 1 exactly when the identification code is not 0x1.
- R12: The enable register stores the 4-bit ier_wdata. ier_rdata bits 7:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable write data: bit0 data/timeout, bit1 holding empty, bit2 line status, bit3 modem |
| ier_rdata | output | 8 | Enable register read value |
| iir_rd | input | 1 | Identification byte read strobe |
| iir_value | output | 8 | Identification byte |
| lsr_rd | input | 1 | Line-status read strobe |
| lsr_value | output | 8 | Line-status byte |
| thr_wr | input | 1 | Holding register write strobe |
| thr_drained | input | 1 | Holding register moved to the shifter |
| tx_shift_idle | input | 1 | Transmit shifter idle |
| rx_ready | input | 1 | Receive data ready |
| rx_overrun | input | 1 | Overrun event pulse |
| rx_break | input | 1 | Break event pulse |
| rx_parity_err | input | 1 | Parity error level |
| rx_frame_err | input | 1 | Framing error level |
| fifo_en | input | 1 | FIFO mode enabled |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trigger | input | CNT_W | Receive trigger level |
| char_timeout | input | 1 | Character timeout pending |
| modem_delta | input | 4 | Modem-status delta bits |
| irq | output | 1 | Level interrupt output |

## Verification
Sources are added one at a time, each above the ones already pending, so that every step of the priority order is observed as a code change. Each source is then removed or masked again so that the lower codes show through. Received data is tried with FIFO mode off, and with FIFO mode on both below and at the trigger level; this separates the trigger gating from plain data-ready. The holding-empty flag is driven through each transition of its state machine. These include an enable rewrite that leaves bit 1 unchanged, which distinguishes a bit-change re-arm from any-write re-arm. Line-status reads are issued with a level error held and with a same-cycle overrun pulse, which separates the sticky clear from the level bits and from set-wins ordering.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        SRC_MODEM   = 4'h0,
        SRC_NONE    = 4'h1,
        SRC_THR     = 4'h2,
        SRC_RXDATA  = 4'h4,
        SRC_LINE    = 4'h6,
        SRC_TIMEOUT = 4'hC
    } irq_src_e;

    typedef enum logic [1:0] {
        HOLD_FULL   = 2'd0,
        EMPTY_ARMED = 2'd1,
        EMPTY_QUIET = 2'd2
    } hold_state_e;

    localparam int EN_W      = 4;
    localparam int EN_RXDATA = 0;
    localparam int EN_THR    = 1;
    localparam int EN_LINE   = 2;
    localparam int EN_MODEM  = 3;

    localparam int STICKY_N  = 2;
    localparam int STK_OE    = 0;
    localparam int STK_BI    = 1;

endpackage

// File: rtl/uart_irq_hold_fsm.sv
module uart_irq_hold_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thr_wr,
    input  logic thr_drained,
    input  logic en_chg,
    input  logic en_new,
    input  logic ack,
    output logic hold_empty,
    output logic thr_pend
);

    hold_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EMPTY_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (thr_wr) begin
            state_d = HOLD_FULL;
        end else begin
            unique case (state_q)
                HOLD_FULL: begin
                    if (thr_drained) state_d = EMPTY_ARMED;
                end
                EMPTY_ARMED: begin
                    if (en_chg)   state_d = en_new ? EMPTY_ARMED : EMPTY_QUIET;
                    else if (ack) state_d = EMPTY_QUIET;
                end
                EMPTY_QUIET: begin
                    if (en_chg && en_new) state_d = EMPTY_ARMED;
                end
                default: state_d = EMPTY_QUIET;
            endcase
        end
    end

    always_comb begin
        hold_empty = 1'b0;
        thr_pend   = 1'b0;
        unique case (state_q)
            HOLD_FULL:   begin hold_empty = 1'b0; thr_pend = 1'b0; end
            EMPTY_ARMED: begin hold_empty = 1'b1; thr_pend = 1'b1; end
            EMPTY_QUIET: begin hold_empty = 1'b1; thr_pend = 1'b0; end
            default:     begin hold_empty = 1'b1; thr_pend = 1'b0; end
        endcase
    end

endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         clr,
    output logic [N-1:0] flag
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag[g] <= 1'b0;
            end else if (set_evt[g]) begin
                flag[g] <= 1'b1;
            end else if (clr) begin
                flag[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [EN_W-1:0] en,
    input  logic            line_any,
    input  logic            timeout,
    input  logic            rx_hit,
    input  logic            thr_pend,
    input  logic            modem_any,
    output irq_src_e        src
);

    always_comb begin
        if (en[EN_LINE] && line_any)        src = SRC_LINE;
        else if (en[EN_RXDATA] && timeout)  src = SRC_TIMEOUT;
        else if (en[EN_RXDATA] && rx_hit)   src = SRC_RXDATA;
        else if (en[EN_THR] && thr_pend)    src = SRC_THR;
        else if (en[EN_MODEM] && modem_any) src = SRC_MODEM;
        else                                src = SRC_NONE;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [3:0]       ier_wdata,
    output logic [7:0]       ier_rdata,
    input  logic             iir_rd,
    output logic [7:0]       iir_value,
    input  logic             lsr_rd,
    output logic [7:0]       lsr_value,
    input  logic             thr_wr,
    input  logic             thr_drained,
    input  logic             tx_shift_idle,
    input  logic             rx_ready,
    input  logic             rx_overrun,
    input  logic             rx_break,
    input  logic             rx_parity_err,
    input  logic             rx_frame_err,
    input  logic             fifo_en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trigger,
    input  logic             char_timeout,
    input  logic [3:0]       modem_delta,
    output logic             irq
);

    localparam int BYTE_W = 8;
    localparam int PAD_W  = BYTE_W - EN_W;

    logic [EN_W-1:0]     en_q;
    logic [STICKY_N-1:0] sticky;
    logic                hold_empty;
    logic                thr_pend;
    logic                en_chg;
    logic                ack;
    logic                rx_hit;
    logic                line_any;
    irq_src_e            src;
    logic [BYTE_W-1:0]   iir_q;
    logic                irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (ier_wr) begin
            en_q <= ier_wdata;
        end
    end

    assign en_chg = ier_wr && (ier_wdata[EN_THR] != en_q[EN_THR]);
    assign ack    = iir_rd && (iir_q[3:0] == SRC_THR);

    uart_irq_hold_fsm u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr_wr      (thr_wr),
        .thr_drained (thr_drained),
        .en_chg      (en_chg),
        .en_new      (ier_wdata[EN_THR]),
        .ack         (ack),
        .hold_empty  (hold_empty),
        .thr_pend    (thr_pend)
    );

    uart_irq_sticky #(.N(STICKY_N)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt ({rx_break, rx_overrun}),
        .clr     (lsr_rd),
        .flag    (sticky)
    );

    assign line_any = sticky[STK_OE] | sticky[STK_BI] | rx_parity_err | rx_frame_err;
    assign rx_hit   = rx_ready && (!fifo_en || (rx_count >= rx_trigger));

    uart_irq_prio u_prio (
        .en        (en_q),
        .line_any  (line_any),
        .timeout   (char_timeout),
        .rx_hit    (rx_hit),
        .thr_pend  (thr_pend),
        .modem_any (|modem_delta),
        .src       (src)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iir_q <= {4'h0, SRC_NONE};
            irq_q <= 1'b0;
        end else begin
            iir_q <= {{2{fifo_en}}, 2'b00, src};
            irq_q <= (src != SRC_NONE);
        end
    end

    assign iir_value = iir_q;
    assign irq       = irq_q;
    assign ier_rdata = {{PAD_W{1'b0}}, en_q};
    assign lsr_value = {1'b0, hold_empty & tx_shift_idle, hold_empty,
                        sticky[STK_BI], rx_frame_err, rx_parity_err,
                        sticky[STK_OE], rx_ready};

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ier_wr,
    input logic [3:0] ier_wdata,
    input logic [7:0] ier_rdata,
    input logic [7:0] iir_value,
    input logic       lsr_rd,
    input logic [7:0] lsr_value,
    input logic       thr_wr,
    input logic       rx_overrun,
    input logic       rx_break,
    input logic       fifo_en,
    input logic       irq
);

    logic started;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    // R11
    irq_matches_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_value[3:0] != 4'h1));

    // R12
    enable_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> ier_rdata == {4'h0, $past(ier_wdata)});

    // R10
    holding_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (!lsr_value[5] && !lsr_value[6]));

    // R7
    status_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !rx_overrun && !rx_break) |=> (!lsr_value[1] && !lsr_value[4]));

    // R4
    line_status_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rdata[2] && (lsr_value[4:1] != 4'h0)) |=> iir_value[3:0] == 4'h6);

    // R3
    fifo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (iir_value[7:6] == {2{$past(fifo_en)}} && iir_value[5:4] == 2'b00));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ier_wr     (ier_wr),
    .ier_wdata  (ier_wdata),
    .ier_rdata  (ier_rdata),
    .iir_value  (iir_value),
    .lsr_rd     (lsr_rd),
    .lsr_value  (lsr_value),
    .thr_wr     (thr_wr),
    .rx_overrun (rx_overrun),
    .rx_break   (rx_break),
    .fifo_en    (fifo_en),
    .irq        (irq)
);

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;

    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ier_wr = 0, iir_rd = 0, lsr_rd = 0, thr_wr = 0, thr_drained = 0;
    logic [3:0]    ier_wdata = '0;
    logic          tx_shift_idle = 1, rx_ready = 0, rx_overrun = 0, rx_break = 0;
    logic          rx_parity_err = 0, rx_frame_err = 0, fifo_en = 0, char_timeout = 0;
    logic [CW-1:0] rx_count = '0, rx_trigger = 5'd1;
    logic [3:0]    modem_delta = '0;
    logic [7:0]    ier_rdata, iir_value, lsr_value;
    logic          irq;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    // reference model state
    logic [3:0] m_ier;
    logic       m_oe, m_bi, m_thre, m_pend;
    logic [7:0] exp_iir;
    logic       exp_irq;

    always #2.5 clk = ~clk;

    uart_irq_ident #(.CNT_W(CW)) i_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .ier_rdata(ier_rdata), .iir_rd(iir_rd), .iir_value(iir_value),
        .lsr_rd(lsr_rd), .lsr_value(lsr_value), .thr_wr(thr_wr),
        .thr_drained(thr_drained), .tx_shift_idle(tx_shift_idle),
        .rx_ready(rx_ready), .rx_overrun(rx_overrun), .rx_break(rx_break),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .fifo_en(fifo_en), .rx_count(rx_count), .rx_trigger(rx_trigger),
        .char_timeout(char_timeout), .modem_delta(modem_delta), .irq(irq)
    );

    function automatic logic [3:0] ref_code();
        if (m_ier[2] && (m_oe || m_bi || rx_parity_err || rx_frame_err)) return 4'h6;
        if (m_ier[0] && char_timeout) return 4'hC;
        if (m_ier[0] && rx_ready && (!fifo_en || rx_count >= rx_trigger)) return 4'h4;
        if (m_ier[1] && m_pend) return 4'h2;
        if (m_ier[3] && modem_delta != 0) return 4'h0;
        return 4'h1;
    endfunction

    always @(posedge clk) begin
        logic [7:0] shown;
        logic [3:0] c;
        if (!rst_n) begin
            m_ier = 0; m_oe = 0; m_bi = 0; m_thre = 1; m_pend = 0;
            exp_iir = 8'h01; exp_irq = 0;
        end else begin
            shown = exp_iir;
            c = ref_code();
            exp_iir = {{2{fifo_en}}, 2'b00, c};
            exp_irq = (c != 4'h1);
            if (rx_overrun) m_oe = 1; else if (lsr_rd) m_oe = 0;
            if (rx_break)   m_bi = 1; else if (lsr_rd) m_bi = 0;
            if (thr_wr) begin
                m_thre = 0; m_pend = 0;
            end else if (thr_drained && !m_thre) begin
                m_thre = 1; m_pend = 1;
            end else if (ier_wr && ier_wdata[1] != m_ier[1]) begin
                m_pend = ier_wdata[1] && m_thre;
            end else if (iir_rd && shown[3:0] == 4'h2) begin
                m_pend = 0;
            end
            if (ier_wr) m_ier = ier_wdata;
        end
    end

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model, mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check8(iir_value, exp_iir, "R2 identification byte");
            check8({7'd0, irq}, {7'd0, exp_irq}, "R11 irq line");
            check8(lsr_value, {1'b0, m_thre & tx_shift_idle, m_thre, m_bi,
                               rx_frame_err, rx_parity_err, m_oe, rx_ready}, "R7 line status");
            check8(ier_rdata, {4'h0, m_ier}, "R12 enable readback");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R11 watchdog expired: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic settle(); repeat (3) @(posedge clk); @(negedge clk); endtask
    task automatic wr_ier(input logic [3:0] v);
        tick(); ier_wr = 1; ier_wdata = v; tick(); ier_wr = 0;
    endtask
    task automatic pulse_iir_rd(); tick(); iir_rd = 1; tick(); iir_rd = 0; endtask
    task automatic pulse_lsr_rd(); tick(); lsr_rd = 1; tick(); lsr_rd = 0; endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check8(iir_value, 8'h01, "R1 reset identification");
        check8({7'd0, irq}, 8'h00, "R1 reset irq");
        check8(lsr_value, 8'h60, "R1 reset line status");
        check8(ier_rdata, 8'h00, "R1 reset enable");

        wr_ier(4'hA); settle();
        check8(ier_rdata, 8'h0A, "R12 upper enable bits zero");
        check8(iir_value, 8'h02, "R9 rising bit1 arms holding empty");
        check8({7'd0, irq}, 8'h01, "R11 irq with code 0x2");

        pulse_iir_rd(); settle();
        check8(iir_value, 8'h01, "R8 read showing 0x2 clears pending");

        tick(); modem_delta = 4'b0001; settle();
        check8(iir_value, 8'h00, "R2 modem lowest priority");

        wr_ier(4'hA); settle();
        check8(iir_value, 8'h00, "R9 unchanged bit1 leaves pending clear");

        tick(); thr_wr = 1; tick(); thr_wr = 0; settle();
        check8(lsr_value, 8'h00, "R10 holding write clears THRE TEMT");
        tick(); thr_drained = 1; tick(); thr_drained = 0; settle();
        check8(iir_value, 8'h02, "R10 drain arms pending over modem");
        check8(lsr_value, 8'h60, "R10 drain sets THRE TEMT");

        pulse_iir_rd(); settle();
        check8(iir_value, 8'h00, "R8 acknowledge exposes modem");
        pulse_iir_rd(); settle();
        check8(iir_value, 8'h00, "R8 read showing 0x0 no effect");

        tick(); modem_delta = 0;
        wr_ier(4'h8); wr_ier(4'hA); settle();
        check8(iir_value, 8'h02, "R9 bit1 toggle re-arms");

        wr_ier(4'hB); tick(); rx_ready = 1; settle();
        check8(iir_value, 8'h04, "R5 data ready without FIFO");

        tick(); fifo_en = 1; rx_trigger = 5'd4; rx_count = 5'd2; settle();
        check8(iir_value, 8'hC2, "R5 below trigger level");
        tick(); rx_count = 5'd4; settle();
        check8(iir_value, 8'hC4, "R3 R5 at trigger level with FIFO bits");

        tick(); char_timeout = 1; settle();
        check8(iir_value, 8'hCC, "R6 timeout above data");
        wr_ier(4'hA); settle();
        check8(iir_value, 8'hC2, "R6 timeout masked by bit0");
        wr_ier(4'hF); settle();
        check8(iir_value, 8'hCC, "R6 timeout unmasked");

        tick(); rx_overrun = 1; tick(); rx_overrun = 0; settle();
        check8(iir_value, 8'hC6, "R4 overrun line status");
        check8(lsr_value, 8'h63, "R7 overrun sticky");
        pulse_lsr_rd(); settle();
        check8(iir_value, 8'hCC, "R7 read clears overrun");

        tick(); rx_break = 1; rx_parity_err = 1; tick(); rx_break = 0; settle();
        check8(lsr_value, 8'h75, "R7 break and parity shown");
        pulse_lsr_rd(); settle();
        check8(lsr_value, 8'h65, "R7 parity survives read");
        check8(iir_value, 8'hC6, "R4 parity level keeps 0x6");

        tick(); rx_parity_err = 0; lsr_rd = 1; rx_overrun = 1;
        tick(); lsr_rd = 0; rx_overrun = 0; settle();
        check8(lsr_value, 8'h63, "R7 set wins over same-cycle read");
        pulse_lsr_rd(); settle();

        tick(); fifo_en = 0; settle();
        check8(iir_value, 8'h0C, "R3 FIFO bits 00 when disabled");

        wr_ier(4'hB); tick(); rx_overrun = 1; tick(); rx_overrun = 0; settle();
        check8(iir_value, 8'h0C, "R4 bit2 clear masks line status");
        check8(lsr_value, 8'h63, "R4 overrun still recorded");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule